// File: doc/BRIEF.md
# Cross-Clock Enable and Soft-Reset Control Front End

This block is the register front end of a peripheral whose serial core runs on its own generic clock. It accepts APB-style reads and writes on the bus clock and keeps the peripheral's configuration fields. It carries enable and software-reset commands into the core clock domain over a toggle handshake with two-flop synchronizers in both directions. The block also reports busy flags that show which commands the core has not yet applied. A software reset overrides everything else in the same write. While the reset is in flight, register writes are refused with an error response and reads return reset contents.

The register map has three words, decoded from `paddr[3:2]`. The control word is at 0x0: bit 0 soft reset, bit 1 enable, bits 4:2 mode, bit 5 clock polarity, bit 6 clock phase, bit 7 LSB-first, bits 11:8 frame format, bits 13:12 input pad select and bits 15:14 output pad select. The busy word is at 0x4: bit 0 reset busy and bit 1 enable busy. A debug word at 0x8 holds one bit, bit 0. All other bits and addresses read 0. Each access completes in a single access phase and there are no wait states.

Top module: `ctrl_sync_frontend`

## Requirements
- R1: After bus reset the control word reads 0, the busy word reads 0 and `core_enable` is 0.
- R2: With enable reading 0, a control write with bit 0 clear stores bits 15:2 (the configuration fields). These bits read back at address 0x0 and appear on `cfg_out`.
- R3: While enable reads 1, a control write leaves bits 15:2 unchanged. The enable bit in that write still takes effect.
- R4: A write that changes enable reads back the new value at once, and busy bit 1 reads 1. When the core has applied the change, busy bit 1 returns to 0 and `core_enable` equals the written value.
- R5: While busy bit 1 is set, the enable bit of a further control write is ignored. The in-flight command is neither lost nor repeated.
- R6: A control write with bit 0 set discards all other bits of that write. It clears enable and every configuration field.
- R7: After a soft-reset write, the control word reads 0x1 and busy bit 0 reads 1. Both clear together once the core has completed the reset. `core_reset` pulses for exactly one core-clock cycle per soft reset.
- R8: Any write while busy bit 0 is set returns `pslverr`=1 and changes no register.
- R9: Reads while busy bit 0 is set return reset contents: the control word reads 0x1 and busy bit 1 reads 0.
- R10: A soft reset leaves the debug bit unchanged and leaves `core_enable` at 0.
- R11: A soft-reset write that arrives while an enable change is still in flight is accepted without error. After both commands finish, both busy flags read 0, enable reads 0 and `core_enable` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Bus-domain reset, active low |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 4 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| pslverr | output | 1 | Error response for refused writes |
| cfg_out | output | 14 | Stored configuration fields (control bits 15:2) |
| gclk | input | 1 | Core generic clock |
| grst_n | input | 1 | Core-domain reset, active low |
| core_enable | output | 1 | Enable as applied in the core domain |
| core_reset | output | 1 | One-cycle soft-reset strobe in the core domain |

## Verification
The bench targets four cases. The first is a second enable write that lands while the first is in flight. A design that accepts it would leave the core in the wrong state or issue a duplicate toggle. The second is a soft reset that carries set enable and configuration bits. A design without reset precedence would come out of reset enabled or configured. The third is a write during the reset window: a design that drops the error or lets the write through would alter the debug bit. The fourth is a soft reset issued while an enable command is still crossing. A design that does not queue it would lose the reset, leave a busy flag stuck, or leave the core enabled.

// File: rtl/ctrl_sync_pkg.sv
package ctrl_sync_pkg;
  localparam int DATA_W  = 32;
  localparam int CFG_W   = 14;
  localparam int CFG_LSB = 2;

  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_BUSY = 2'd1;
  localparam logic [1:0] IDX_DBG  = 2'd2;

  function automatic logic [DATA_W-1:0] ctrl_word(input logic srst,
                                                  input logic en,
                                                  input logic [CFG_W-1:0] cfg);
    logic [DATA_W-1:0] w;
    w = '0;
    w[0] = srst;
    w[1] = en;
    w[CFG_LSB +: CFG_W] = cfg;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] busy_word(input logic rst_busy,
                                                  input logic en_busy);
    logic [DATA_W-1:0] w;
    w = '0;
    w[0] = rst_busy;
    w[1] = en_busy & ~rst_busy;
    return w;
  endfunction
endpackage

// File: rtl/cdc_sync.sv
module cdc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[i] <= 1'b0;
        else if (i == 0) stage[i] <= d;
        else stage[i] <= stage[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
  import ctrl_sync_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [AW-1:0]     paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pslverr,
  input  logic              ack_sync,
  output logic              req_tgl,
  output logic              cmd_rst,
  output logic              cmd_en,
  output logic              en_reg,
  output logic [CFG_W-1:0]  cfg,
  output logic              srst_busy,
  output logic              en_busy,
  output logic              srst_wr,
  output logic              ack_done
);
  localparam int IDX_W = AW - 2;

  logic [IDX_W-1:0] idx;
  logic wr, wr_ok, ctrl_wr, dbg_wr, en_change, launch_rst;
  logic chan_busy, chan_busy_q, srst_pend, dbg;
  logic unused_bits;

  assign idx        = paddr[AW-1:2];
  assign wr         = psel & penable & pwrite;
  assign wr_ok      = wr & ~srst_busy;
  assign srst_wr    = wr_ok & (idx == IDX_W'(IDX_CTRL)) & pwdata[0];
  assign ctrl_wr    = wr_ok & (idx == IDX_W'(IDX_CTRL)) & ~pwdata[0];
  assign dbg_wr     = wr_ok & (idx == IDX_W'(IDX_DBG));
  assign en_change  = ctrl_wr & ~en_busy & (pwdata[1] != en_reg);
  assign chan_busy  = req_tgl ^ ack_sync;
  assign ack_done   = chan_busy_q & ~chan_busy;
  assign launch_rst = srst_pend & ~chan_busy;
  assign pslverr    = wr & srst_busy;
  assign unused_bits = ^{pwdata[DATA_W-1:CFG_LSB+CFG_W], paddr[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_reg      <= 1'b0;
      cfg         <= '0;
      dbg         <= 1'b0;
      req_tgl     <= 1'b0;
      cmd_rst     <= 1'b0;
      cmd_en      <= 1'b0;
      srst_pend   <= 1'b0;
      srst_busy   <= 1'b0;
      en_busy     <= 1'b0;
      chan_busy_q <= 1'b0;
    end else begin
      chan_busy_q <= chan_busy;
      if (ack_done) begin
        if (cmd_rst) srst_busy <= 1'b0;
        else         en_busy   <= 1'b0;
      end
      if (srst_wr) begin
        en_reg    <= 1'b0;
        cfg       <= '0;
        srst_pend <= 1'b1;
        srst_busy <= 1'b1;
      end else if (ctrl_wr) begin
        if (!en_reg) cfg <= pwdata[CFG_LSB +: CFG_W];
        if (en_change) begin
          en_reg  <= pwdata[1];
          en_busy <= 1'b1;
          req_tgl <= ~req_tgl;
          cmd_rst <= 1'b0;
          cmd_en  <= pwdata[1];
        end
      end
      if (dbg_wr) dbg <= pwdata[0];
      if (launch_rst) begin
        req_tgl   <= ~req_tgl;
        cmd_rst   <= 1'b1;
        cmd_en    <= 1'b0;
        srst_pend <= 1'b0;
      end
    end
  end

  always_comb begin
    prdata = '0;
    case (idx)
      IDX_W'(IDX_CTRL): prdata = srst_busy ? ctrl_word(1'b1, 1'b0, '0)
                                           : ctrl_word(1'b0, en_reg, cfg);
      IDX_W'(IDX_BUSY): prdata = busy_word(srst_busy, en_busy);
      IDX_W'(IDX_DBG):  prdata[0] = dbg;
      default:          prdata = '0;
    endcase
  end
endmodule

// File: rtl/core_apply.sv
module core_apply (
  input  logic clk,
  input  logic rst_n,
  input  logic req_sync,
  input  logic cmd_rst,
  input  logic cmd_en,
  output logic ack_tgl,
  output logic core_enable,
  output logic core_reset
);
  logic req_q, evt;

  assign evt = req_sync ^ req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q       <= 1'b0;
      ack_tgl     <= 1'b0;
      core_enable <= 1'b0;
      core_reset  <= 1'b0;
    end else begin
      req_q      <= req_sync;
      core_reset <= 1'b0;
      if (evt) begin
        ack_tgl <= ~ack_tgl;
        if (cmd_rst) begin
          core_enable <= 1'b0;
          core_reset  <= 1'b1;
        end else begin
          core_enable <= cmd_en;
        end
      end
    end
  end
endmodule

// File: rtl/ctrl_sync_frontend.sv
module ctrl_sync_frontend
  import ctrl_sync_pkg::*;
#(
  parameter int AW        = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [AW-1:0]     paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pslverr,
  output logic [CFG_W-1:0]  cfg_out,
  input  logic              gclk,
  input  logic              grst_n,
  output logic              core_enable,
  output logic              core_reset
);
  logic req_tgl, req_sync, ack_tgl, ack_sync;
  logic cmd_rst, cmd_en, en_reg, srst_busy, en_busy, srst_wr, ack_done;
  logic [CFG_W-1:0] cfg;

  assign cfg_out = cfg;

  ctrl_regs #(.AW(AW)) u_regs (
    .clk(pclk), .rst_n(presetn),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pslverr(pslverr),
    .ack_sync(ack_sync), .req_tgl(req_tgl), .cmd_rst(cmd_rst), .cmd_en(cmd_en),
    .en_reg(en_reg), .cfg(cfg), .srst_busy(srst_busy), .en_busy(en_busy),
    .srst_wr(srst_wr), .ack_done(ack_done)
  );

  cdc_sync #(.STAGES(SYNC_DEPTH)) u_req_sync (
    .clk(gclk), .rst_n(grst_n), .d(req_tgl), .q(req_sync)
  );

  cdc_sync #(.STAGES(SYNC_DEPTH)) u_ack_sync (
    .clk(pclk), .rst_n(presetn), .d(ack_tgl), .q(ack_sync)
  );

  core_apply u_core (
    .clk(gclk), .rst_n(grst_n), .req_sync(req_sync),
    .cmd_rst(cmd_rst), .cmd_en(cmd_en), .ack_tgl(ack_tgl),
    .core_enable(core_enable), .core_reset(core_reset)
  );
endmodule

// File: rtl/ctrl_sync_chk.sv
module ctrl_sync_chk
  import ctrl_sync_pkg::*;
(
  input logic             pclk,
  input logic             presetn,
  input logic             gclk,
  input logic             grst_n,
  input logic             pslverr,
  input logic             srst_busy,
  input logic             en_busy,
  input logic             en_reg,
  input logic [CFG_W-1:0] cfg,
  input logic             srst_wr,
  input logic             ack_done,
  input logic             core_enable,
  input logic             core_reset
);
  AST_ERR_ONLY_IN_RESET: assert property (@(posedge pclk) disable iff (!presetn)
    pslverr |-> srst_busy); // R8

  AST_EN_HOLD_WHILE_BUSY: assert property (@(posedge pclk) disable iff (!presetn)
    (en_busy && !srst_wr) |=> $stable(en_reg)); // R5

  AST_CFG_LOCKED: assert property (@(posedge pclk) disable iff (!presetn)
    (en_reg && !srst_wr) |=> $stable(cfg)); // R3

  AST_RST_BUSY_CLEARS_ON_ACK: assert property (@(posedge pclk) disable iff (!presetn)
    $fell(srst_busy) |-> $past(ack_done)); // R7

  AST_CORE_RESET_DISABLES: assert property (@(posedge gclk) disable iff (!grst_n)
    core_reset |-> !core_enable); // R10

  AST_CORE_RESET_ONE_CYCLE: assert property (@(posedge gclk) disable iff (!grst_n)
    core_reset |=> !core_reset); // R7
endmodule

bind ctrl_sync_frontend ctrl_sync_chk u_chk (
  .pclk(pclk), .presetn(presetn), .gclk(gclk), .grst_n(grst_n),
  .pslverr(pslverr), .srst_busy(srst_busy), .en_busy(en_busy),
  .en_reg(en_reg), .cfg(cfg), .srst_wr(srst_wr), .ack_done(ack_done),
  .core_enable(core_enable), .core_reset(core_reset)
);

// File: tb/tb_ctrl_sync_frontend.sv
module tb_ctrl_sync_frontend;
  logic pclk = 1'b0, gclk = 1'b0, presetn = 1'b0, grst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [3:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pslverr, core_enable, core_reset;
  logic [13:0] cfg_out;

  int checks = 0, failures = 0, pulses = 0, cyc = 0;
  bit done = 0;

  // behavioural reference state
  bit        m_en = 0, m_rst = 0, m_enbusy = 0, m_dbg = 0, m_core_en = 0;
  bit [13:0] m_cfg = '0;

  always #5 pclk = ~pclk;
  always #8 gclk = ~gclk;

  ctrl_sync_frontend dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pslverr(pslverr), .cfg_out(cfg_out), .gclk(gclk), .grst_n(grst_n),
    .core_enable(core_enable), .core_reset(core_reset)
  );

  always @(posedge gclk) if (core_reset) pulses++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // configuration fields compared on every bus clock
  always @(negedge pclk) begin
    cyc++;
    if (!done) chk("R2/R3 cfg_out", {18'b0, cfg_out}, {18'b0, m_cfg});
  end

  function automatic logic [31:0] exp_ctrl();
    return m_rst ? 32'h1 : {16'b0, m_cfg, m_en, 1'b0};
  endfunction

  task automatic apb_write(input string req, input logic [3:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1;
    #1 chk({req, " pslverr"}, {31'b0, pslverr}, {31'b0, m_rst});
    @(posedge pclk);
    #1;
    if (!m_rst) begin
      if (a == 4'h0) begin
        if (d[0]) begin
          m_rst = 1; m_en = 0; m_cfg = '0; m_core_en = 0;
        end else begin
          if (!m_en) m_cfg = d[15:2];
          if (!m_enbusy && d[1] != m_en) begin
            m_en = d[1]; m_enbusy = 1; m_core_en = d[1];
          end
        end
      end else if (a == 4'h8) m_dbg = d[0];
    end
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge pclk);
    penable = 1;
    #1 chk(req, prdata, exp);
    @(negedge pclk);
    psel = 0; penable = 0;
  endtask

  task automatic settle();
    repeat (40) @(posedge pclk);
    m_rst = 0; m_enbusy = 0;
  endtask

  initial begin
    repeat (3) @(posedge pclk);
    presetn = 1; grst_n = 1;
    repeat (2) @(posedge pclk);

    // R1 reset state
    apb_read("R1 ctrl", 4'h0, 32'h0);
    apb_read("R1 busy", 4'h4, 32'h0);
    chk("R1 core_enable", {31'b0, core_enable}, 32'h0);

    // R2 configuration while disabled
    apb_write("R2", 4'h0, 32'h0000_A5A4);
    apb_read("R2 ctrl", 4'h0, exp_ctrl());

    // R4 enable with configuration in same write
    apb_write("R4", 4'h0, 32'h0000_1232);
    apb_read("R4 ctrl", 4'h0, exp_ctrl());
    apb_read("R4 busy set", 4'h4, 32'h2);
    settle();
    apb_read("R4 busy clear", 4'h4, 32'h0);
    chk("R4 core_enable", {31'b0, core_enable}, {31'b0, m_core_en});

    // R3 configuration locked while enabled
    apb_write("R3", 4'h0, 32'h0000_FF02);
    apb_read("R3 ctrl", 4'h0, exp_ctrl());

    // R5 second enable write while first in flight
    apb_write("R5 first", 4'h0, 32'h0000_0000);
    apb_write("R5 second", 4'h0, 32'h0000_0002);
    apb_read("R5 ctrl", 4'h0, exp_ctrl());
    settle();
    chk("R5 core_enable", {31'b0, core_enable}, {31'b0, m_core_en});
    apb_read("R5 busy", 4'h4, 32'h0);

    // R2 full field width
    apb_write("R2 full", 4'h0, 32'h0000_FFFC);
    apb_read("R2 full ctrl", 4'h0, exp_ctrl());

    apb_write("R10 dbg", 4'h8, 32'h1);
    apb_read("R10 dbg", 4'h8, 32'h1);
    apb_write("R4 en", 4'h0, 32'h0000_FFFE);
    settle();
    chk("R4 core_enable on", {31'b0, core_enable}, 32'h1);

    // R6 R7 R8 R9 soft reset with all bits set
    apb_write("R6", 4'h0, 32'hFFFF_FFFF);
    apb_read("R9 ctrl during reset", 4'h0, 32'h1);
    apb_write("R8 write during reset", 4'h8, 32'h0);
    settle();
    apb_read("R6 ctrl after", 4'h0, 32'h0);
    apb_read("R7 busy after", 4'h4, 32'h0);
    apb_read("R10 dbg kept", 4'h8, {31'b0, m_dbg});
    chk("R10 core_enable", {31'b0, core_enable}, 32'h0);
    chk("R7 pulses", pulses, 1);

    // R11 soft reset while enable in flight
    apb_write("R11 en", 4'h0, 32'h0000_0002);
    apb_write("R11 srst", 4'h0, 32'h0000_0001);
    apb_read("R9 busy during reset", 4'h4, 32'h1);
    settle();
    apb_read("R11 busy", 4'h4, 32'h0);
    apb_read("R11 ctrl", 4'h0, 32'h0);
    chk("R11 core_enable", {31'b0, core_enable}, 32'h0);
    chk("R11 pulses", pulses, 2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; failures++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule